// File: doc/BRIEF.md
# Raster Timing Generator

This block paces a video transmitter. It counts pixels along each line and lines down each frame, and from those two positions it derives the horizontal sync, the vertical sync, a data-enable that marks the displayed area, and a single-cycle marker for the first pixel of every frame. The current pixel and line numbers are also driven out so that a pixel source can address its data.

Software sets the raster geometry through a small write-only register file. Each timing word holds a horizontal count in its low half and a vertical count in its high half. A separate word sets the sync polarities and a clock-inversion flag. A control word holds the run enable and a link-mode flag. In the link-mode flag, a set bit selects HDMI framing and a clear bit selects plain DVI. The block exports that flag for the encoder downstream. The blanking word does not hold the true back porch: it holds the whole span from the start of sync to the end of the line or frame. The block therefore places the sync pulse at the head of that span, and the true back porch is what remains after it.

Geometry and polarity writes go into live registers. They are copied into working registers only at the boundary of a frame, so a frame that is already running keeps its shape.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all registers are zero. The outputs show pix_x = 0, line_y = 0, de = 0, frame_start = 0, hdmi_mode = 0 and tx_clk_inv = 0, and hsync and vsync are both 1, because a zero polarity bit means active-low.
- R2: A write with wr_en = 1 stores wr_data at wr_addr. The map is: 0 = displayed size, 1 = sync-to-end span, 2 = front porch, 3 = sync width, 4 = polarity, 5 = control. Every timing word carries the horizontal value in bits [15:0] and the vertical value in bits [31:16].
- R3: While enabled, pix_x counts from 0 up to H_total − 1 and then wraps to 0. line_y advances once per line and wraps after V_total − 1. The totals are computed as total = displayed + front porch + span.
- R4: de is 1 exactly when the block is enabled, pix_x < displayed X and line_y < displayed Y.
- R5: The horizontal sync is asserted for pix_x in [dispX + frontX, dispX + frontX + syncX). The rest of the line after the pulse (spanX − syncX cycles) is the true back porch.
- R6: The vertical sync is asserted on the lines line_y in [dispY + frontY, dispY + frontY + syncY).
- R7: In the polarity word, bit 0 set makes hsync active-high and bit 1 set makes vsync active-high. A clear bit makes the matching sync active-low. Bit 2 is driven out on tx_clk_inv.
- R8: Control bit 0 enables the block. While this bit is 0, pix_x and line_y hold at 0, de is 0, frame_start is 0, and both syncs sit at their inactive level. Control bit 1 appears on hdmi_mode in the cycle after the write.
- R9: While enabled, geometry and polarity writes take effect only from the first pixel of the next frame. While disabled, they take effect within two cycles.
- R10: frame_start is 1 in exactly those cycles where the block is enabled and pix_x = 0 and line_y = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Write data, Y in [31:16], X in [15:0] |
| pix_x | output | 16 | Current pixel within the line |
| line_y | output | 16 | Current line within the frame |
| de | output | 1 | Displayed-area data enable |
| hsync | output | 1 | Horizontal sync at the programmed polarity |
| vsync | output | 1 | Vertical sync at the programmed polarity |
| frame_start | output | 1 | First pixel of a frame |
| hdmi_mode | output | 1 | Link-mode flag (1 = HDMI framing, 0 = DVI) |
| tx_clk_inv | output | 1 | Transmit clock inversion flag |

## Verification
A fault in the pixel counter's wrap shows at once on pix_x and hsync, and within one line on line_y. A fault in the line counter shows on vsync and frame_start within one frame. A shadow copy taken at the wrong time makes de or a sync pulse move in the middle of a frame. That error appears in the same line as the write, well before the next frame boundary that the requirements allow. Every output is compared on every cycle against a reference raster, so each of these faults is caught on the first cycle in which it differs.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned FW = 16;
  localparam int unsigned RW = 2 * FW;
  localparam int unsigned AW = 3;
  localparam int unsigned EW = FW + 2;

  typedef logic [FW-1:0] fld_t;
  typedef logic [EW-1:0] ext_t;

  typedef enum logic [AW-1:0] {
    A_SIZE  = 3'd0,
    A_SPAN  = 3'd1,
    A_FRONT = 3'd2,
    A_PULSE = 3'd3,
    A_POL   = 3'd4,
    A_CTRL  = 3'd5
  } addr_e;

  typedef struct packed {
    fld_t size_x, size_y;
    fld_t front_x, front_y;
    fld_t span_x, span_y;
    fld_t pulse_x, pulse_y;
    logic pol_h, pol_v, pol_clk;
  } cfg_t;

  function automatic fld_t lo_half(input logic [RW-1:0] w);
    return w[FW-1:0];
  endfunction

  function automatic fld_t hi_half(input logic [RW-1:0] w);
    return w[RW-1:FW];
  endfunction

  // full period of one axis: displayed + front porch + sync-to-end span
  function automatic ext_t period(input fld_t size, input fld_t front, input fld_t span);
    return ext_t'(size) + ext_t'(front) + ext_t'(span);
  endfunction

  function automatic ext_t pulse_start(input fld_t size, input fld_t front);
    return ext_t'(size) + ext_t'(front);
  endfunction

  function automatic logic in_window(input fld_t pos, input ext_t lo, input fld_t len);
    ext_t p;
    p = ext_t'(pos);
    return (p >= lo) && (p < lo + ext_t'(len));
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic          load,
  output cfg_t          cfg,
  output logic          en,
  output logic          hdmi
);
  cfg_t live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      en   <= 1'b0;
      hdmi <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_SIZE:  begin live.size_x  <= lo_half(wr_data); live.size_y  <= hi_half(wr_data); end
        A_SPAN:  begin live.span_x  <= lo_half(wr_data); live.span_y  <= hi_half(wr_data); end
        A_FRONT: begin live.front_x <= lo_half(wr_data); live.front_y <= hi_half(wr_data); end
        A_PULSE: begin live.pulse_x <= lo_half(wr_data); live.pulse_y <= hi_half(wr_data); end
        A_POL:   begin
          live.pol_h   <= wr_data[0];
          live.pol_v   <= wr_data[1];
          live.pol_clk <= wr_data[2];
        end
        A_CTRL:  begin en <= wr_data[0]; hdmi <= wr_data[1]; end
        default: ;
      endcase
    end
  end

  // working copy, refreshed only at a frame boundary or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= '0;
    else if (load) cfg <= live;
  end
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  fld_t size,
  input  fld_t front,
  input  fld_t span,
  input  fld_t pulse,
  output fld_t pos,
  output logic last,
  output logic in_act,
  output logic in_sync
);
  ext_t total;

  assign total   = period(size, front, span);
  assign last    = (ext_t'(pos) + ext_t'(1)) == total;
  assign in_act  = pos < size;
  assign in_sync = in_window(pos, pulse_start(size, front), pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (!run) pos <= '0;
    else if (step) pos <= last ? '0 : pos + 1'b1;
  end

  // R3
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !last) |=> (pos == FW'($past(pos) + 1'b1)));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && last) |=> (pos == '0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (pos == '0));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  output logic [FW-1:0] pix_x,
  output logic [FW-1:0] line_y,
  output logic          de,
  output logic          hsync,
  output logic          vsync,
  output logic          frame_start,
  output logic          hdmi_mode,
  output logic          tx_clk_inv
);
  cfg_t cfg;
  logic en, hdmi;
  logic h_last, h_act, h_sync;
  logic v_last, v_act, v_sync;
  logic frame_last, shadow_load;

  assign frame_last  = en && h_last && v_last;
  assign shadow_load = !en || frame_last;

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(shadow_load), .cfg(cfg), .en(en), .hdmi(hdmi)
  );

  rtg_axis u_h (
    .clk(clk), .rst_n(rst_n), .run(en), .step(1'b1),
    .size(cfg.size_x), .front(cfg.front_x), .span(cfg.span_x), .pulse(cfg.pulse_x),
    .pos(pix_x), .last(h_last), .in_act(h_act), .in_sync(h_sync)
  );

  rtg_axis u_v (
    .clk(clk), .rst_n(rst_n), .run(en), .step(h_last),
    .size(cfg.size_y), .front(cfg.front_y), .span(cfg.span_y), .pulse(cfg.pulse_y),
    .pos(line_y), .last(v_last), .in_act(v_act), .in_sync(v_sync)
  );

  assign de          = en && h_act && v_act;
  assign hsync       = (en && h_sync) ? cfg.pol_h : !cfg.pol_h;
  assign vsync       = (en && v_sync) ? cfg.pol_v : !cfg.pol_v;
  assign frame_start = en && (pix_x == '0) && (line_y == '0);
  assign hdmi_mode   = hdmi;
  assign tx_clk_inv  = cfg.pol_clk;

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_last) |=> $stable(cfg));
  // R4
  de_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x < cfg.size_x && line_y < cfg.size_y));
  // R10
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && $past(en)) |=> (!en || frame_start));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] pix_x, line_y;
  logic        de, hsync, vsync, frame_start, hdmi_mode, tx_clk_inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_x(pix_x), .line_y(line_y), .de(de), .hsync(hsync), .vsync(vsync),
    .frame_start(frame_start), .hdmi_mode(hdmi_mode), .tx_clk_inv(tx_clk_inv)
  );

  // reference raster: live words, working copy, counters
  int l_sx, l_sy, l_fx, l_fy, l_bx, l_by, l_px, l_py;
  bit l_ph, l_pv, l_pc, m_en, m_hd;
  int s_sx, s_sy, s_fx, s_fy, s_bx, s_by, s_px, s_py;
  bit s_ph, s_pv, s_pc;
  int mx, my;

  function automatic int line_len(int sz, int fr, int sp);
    return sz + fr + sp;
  endfunction

  function automatic bit pulse_on(int p, int sz, int fr, int w);
    return (p >= sz + fr) && (p < sz + fr + w);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {l_sx, l_sy, l_fx, l_fy, l_bx, l_by, l_px, l_py} = '{default:0};
      {s_sx, s_sy, s_fx, s_fy, s_bx, s_by, s_px, s_py} = '{default:0};
      {l_ph, l_pv, l_pc, s_ph, s_pv, s_pc, m_en, m_hd} = '0;
      mx = 0; my = 0;
    end else begin
      bit hl, fl;
      hl = (mx == line_len(s_sx, s_fx, s_bx) - 1);
      fl = m_en && hl && (my == line_len(s_sy, s_fy, s_by) - 1);
      if (!m_en) begin mx = 0; my = 0; end
      else if (hl) begin
        mx = 0;
        my = (my == line_len(s_sy, s_fy, s_by) - 1) ? 0 : my + 1;
      end else mx = mx + 1;
      if (!m_en || fl) begin
        s_sx = l_sx; s_sy = l_sy; s_fx = l_fx; s_fy = l_fy;
        s_bx = l_bx; s_by = l_by; s_px = l_px; s_py = l_py;
        s_ph = l_ph; s_pv = l_pv; s_pc = l_pc;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin l_sx = int'(wr_data[15:0]); l_sy = int'(wr_data[31:16]); end
          3'd1: begin l_bx = int'(wr_data[15:0]); l_by = int'(wr_data[31:16]); end
          3'd2: begin l_fx = int'(wr_data[15:0]); l_fy = int'(wr_data[31:16]); end
          3'd3: begin l_px = int'(wr_data[15:0]); l_py = int'(wr_data[31:16]); end
          3'd4: begin l_ph = wr_data[0]; l_pv = wr_data[1]; l_pc = wr_data[2]; end
          3'd5: begin m_en = wr_data[0]; m_hd = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit e_de, e_hs, e_vs, e_fs;
      e_de = m_en && mx < s_sx && my < s_sy;
      e_hs = (m_en && pulse_on(mx, s_sx, s_fx, s_px)) ? s_ph : !s_ph;
      e_vs = (m_en && pulse_on(my, s_sy, s_fy, s_py)) ? s_pv : !s_pv;
      e_fs = m_en && mx == 0 && my == 0;
      chk(int'(pix_x) == mx, "R3/R9 pix_x", int'(pix_x), mx);
      chk(int'(line_y) == my, "R3/R9 line_y", int'(line_y), my);
      chk(de == e_de, "R4/R9 de", int'(de), int'(e_de));
      chk(hsync == e_hs, "R2/R5/R7 hsync", int'(hsync), int'(e_hs));
      chk(vsync == e_vs, "R2/R6/R7 vsync", int'(vsync), int'(e_vs));
      chk(frame_start == e_fs, "R10 frame_start", int'(frame_start), int'(e_fs));
      chk(hdmi_mode == m_hd, "R8 hdmi_mode", int'(hdmi_mode), int'(m_hd));
      chk(tx_clk_inv == s_pc, "R7 tx_clk_inv", int'(tx_clk_inv), int'(s_pc));
    end
  end

  task automatic wr(input int a, input int y, input int x);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = {16'(y), 16'(x)};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic geom(input int sx, sy, fx, fy, bx, by, px, py);
    wr(0, sy, sx); wr(1, by, bx); wr(2, fy, fx); wr(3, py, px);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    // R1: reset state
    chk(pix_x == 0 && line_y == 0, "R1 counters", int'(pix_x), 0);
    chk(de == 0 && frame_start == 0, "R1 de/fs", int'(de), 0);
    chk(hsync == 1 && vsync == 1, "R1 syncs", int'({hsync, vsync}), 3);
    chk(hdmi_mode == 0 && tx_clk_inv == 0, "R1 flags", int'({hdmi_mode, tx_clk_inv}), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R2: directed geometry, hsync high, vsync low, HDMI framing
    geom(6, 4, 2, 1, 4, 3, 2, 1);
    wr(4, 0, 32'h5);
    wr(5, 0, 3);
    idle(300);
    // R9: geometry change mid-frame must wait for the next frame
    idle(7);
    geom(3, 2, 1, 2, 2, 2, 1, 1);
    idle(200);
    // R8: disable mid-frame, then check idle outputs
    idle(5);
    wr(5, 0, 2);
    idle(2);
    chk(de == 0 && pix_x == 0 && line_y == 0, "R8 idle", int'(pix_x), 0);
    wr(4, 0, 32'h2);
    idle(3);
    wr(5, 0, 1);
    idle(150);
    // R5/R6 corners: no pulse, zero true back porch, one pixel lines
    geom(1, 1, 0, 0, 0, 0, 0, 0);
    idle(60);
    geom(2, 2, 0, 1, 3, 2, 3, 2);
    idle(120);
    for (int k = 0; k < 18; k++) begin
      int sx, sy, fx, fy, px, py;
      sx = 1 + int'($urandom_range(7)); sy = 1 + int'($urandom_range(7));
      fx = int'($urandom_range(3)); fy = int'($urandom_range(3));
      px = int'($urandom_range(3)); py = int'($urandom_range(3));
      geom(sx, sy, fx, fy, px + int'($urandom_range(3)), py + int'($urandom_range(3)), px, py);
      wr(4, 0, int'($urandom_range(7)));
      if (k % 5 == 4) begin
        wr(5, 0, 0);
        idle(4);
      end
      wr(5, 0, 1 + 2 * int'($urandom_range(1)));
      idle(650);
    end
    cmp_on = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule